// File: doc/BRIEF.md
# Serial Register Access Port

This block is the device-side end of a three-wire host link made of a serial clock, a command/data select line and one data line. The data line is split here into an input, an output and an output enable. While the select line is high the host clocks in control bytes. Each control byte names one of sixteen register addresses and says whether the following data phase reads or writes. While the select line is low and a read has been chosen, the block shifts the chosen register out, least significant bit first.

Fifteen addresses map to plain byte registers. These are loaded from the inside of the chip through a simple write strobe. One address maps to a receive buffer, which behaves as a queue. The protocol logic behind the port feeds that queue through a valid/ready stream.

A push is taken only on a clock edge where both `rx_valid` and `rx_ready` are high. `rx_ready` falls when the queue is full. The producer must then hold its byte and valid until ready returns. A data byte read over the serial link frees a slot.

SCK, C/D and the data input are first brought into the system clock domain and edge-detected. Data bits are sampled on rising SCK and driven on falling SCK. The host must therefore hold each SCK level for at least six system clocks.

Top module: `sreg_port`

## Requirements
- R1: After reset, address 0 is selected with the write direction, so `sio_oe` stays 0 even while SCK toggles with C/D low.
- R2: With C/D high, each rising SCK samples one bit. In each group of eight, bits 0..3 form the address (A0 first), bit 4 selects read (1) or write (0), and bits 5..7 are ignored. The selection changes only on the eighth rising edge.
- R3: A group of fewer than eight rising edges before C/D falls is discarded and leaves the previous selection in place.
- R4: With C/D low and read selected, `sio_oe` is 1, and successive falling SCK edges drive D0 through D7 of the selected byte on `sio_out`. `sio_out` changes only after a falling SCK.
- R5: While C/D is high, `sio_oe` is 0.
- R6: Reading a plain register repeatedly returns the same byte each time; the read does not consume it.
- R7: Reading the receive buffer (address 15) returns queued bytes in arrival order. A byte leaves the queue once its D7 has been driven. An empty queue reads as 0x00 and is not disturbed.
- R8: If C/D rises during a buffer read after at least one bit of a byte was sent, that byte is dropped. The next read starts at the following byte.
- R9: If C/D rises in the middle of a plain register read, the next read restarts at D0 of the same register.
- R10: `rx_ready` is 0 exactly when the queue holds `RX_DEPTH` bytes. A push offered while full is not taken.
- R11: `wr_en` writes `wr_data` into register `wr_addr` on a clock edge. A write aimed at address 15 has no effect on any readable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cd | input | 1 | Command (1) / data (0) select |
| sio_in | input | 1 | Serial data from host |
| sio_out | output | 1 | Serial data to host |
| sio_oe | output | 1 | Drive enable for the data pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rx_valid | input | 1 | Receive-buffer push valid |
| rx_ready | output | 1 | Receive-buffer has space |
| rx_data | input | 8 | Byte to push |

## Verification
Two events can land on the same system clock edge: a push into the receive queue and a pop caused by the serial reader finishing a byte or aborting one. The bench prefills the queue and selects it. It then reads a stream of bytes while a parallel process pushes more bytes with random gaps, so some pushes meet a pop on the same edge. Every byte read is compared with a bench-side queue that records accepted pushes in order. A lost or duplicated byte shows up as a miscompare or as a wrong 0x00 tail.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sreg_rxfifo.sv
module sreg_rxfifo
  import sreg_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  data_t         in_data,
  input  logic          pop,
  output data_t         head,
  output logic          empty,
  output logic [CW-1:0] count
);
  data_t         mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready = (count != CW'(DEPTH));
  assign push     = in_valid & in_ready;
  assign empty    = (count == '0);
  assign head     = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter addr_t SKIP = '1,
  localparam int NREG = 2 ** ADDR_W
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  data_t wr_data,
  input  addr_t rd_addr,
  output data_t rd_data
);
  data_t regs [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= '0;
        else if (wr_en && wr_addr == addr_t'(i) && addr_t'(i) != SKIP) regs[i] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int    RX_DEPTH    = 8,
  parameter int    SYNC_STAGES = 2,
  parameter addr_t BUF_ADDR    = 4'hF,
  localparam int   CW          = $clog2(RX_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cd,
  input  logic       sio_in,
  output logic       sio_out,
  output logic       sio_oe,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data
);
  logic [2:0] pins_s;
  logic       sck_s, cd_s, sio_s, sck_q, cd_q;
  logic       sck_rise, sck_fall, cd_rise;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sio_in, cd, sck}), .q(pins_s));

  assign {sio_s, cd_s, sck_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
      cd_q  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cd_q  <= cd_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cd_rise  = cd_s & ~cd_q;

  // control byte capture
  logic [2:0] ctl_cnt;
  logic [4:0] ctl_sh;
  addr_t      sel_addr;
  logic       sel_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_cnt  <= '0;
      ctl_sh   <= '0;
      sel_addr <= '0;
      sel_rd   <= 1'b0;
    end else if (!cd_s) begin
      ctl_cnt <= '0;
    end else if (sck_rise) begin
      if (ctl_cnt < 3'd5) ctl_sh <= {sio_s, ctl_sh[4:1]};
      ctl_cnt <= ctl_cnt + 1'b1;
      if (ctl_cnt == 3'd7) begin
        sel_addr <= ctl_sh[3:0];
        sel_rd   <= ctl_sh[4];
      end
    end
  end

  // register sources
  data_t          bank_q, fifo_head;
  logic           fifo_empty, pop;
  logic [CW-1:0]  fifo_cnt;

  sreg_bank #(.SKIP(BUF_ADDR)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(sel_addr), .rd_data(bank_q));

  sreg_rxfifo #(.DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_ready(rx_ready),
    .in_data(rx_data), .pop(pop), .head(fifo_head), .empty(fifo_empty),
    .count(fifo_cnt));

  // data read shifter
  logic [2:0] rd_cnt;
  data_t      rd_sh;
  logic       rd_live;
  logic       rd_active, is_buf, abort, last_bit;

  assign rd_active = ~cd_s & sel_rd;
  assign is_buf    = (sel_addr == BUF_ADDR);
  assign abort     = cd_rise & sel_rd & (rd_cnt != '0);
  assign last_bit  = rd_active & sck_fall & (rd_cnt == 3'd7);
  assign pop       = rd_live & (last_bit | abort);
  assign sio_oe    = rd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      rd_sh   <= '0;
      rd_live <= 1'b0;
      sio_out <= 1'b0;
    end else if (abort) begin
      rd_cnt  <= '0;
      rd_live <= 1'b0;
    end else if (rd_active && sck_fall) begin
      rd_cnt <= rd_cnt + 1'b1;
      if (rd_cnt == '0) begin
        if (is_buf) begin
          rd_sh   <= fifo_empty ? '0 : fifo_head;
          sio_out <= fifo_empty ? 1'b0 : fifo_head[0];
          rd_live <= ~fifo_empty;
        end else begin
          rd_sh   <= bank_q;
          sio_out <= bank_q[0];
          rd_live <= 1'b0;
        end
      end else begin
        sio_out <= rd_sh[rd_cnt];
        if (rd_cnt == 3'd7) rd_live <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cd_s,
  input logic          sck_rise,
  input logic          sck_fall,
  input logic [2:0]    ctl_cnt,
  input logic [3:0]    sel_addr,
  input logic          sel_rd,
  input logic          sio_out,
  input logic          sio_oe,
  input logic          rx_ready,
  input logic [CW-1:0] fifo_cnt,
  input logic          pop,
  input logic          fifo_empty
);
  a_r2_sel_on_eighth: assert property (@(posedge clk) disable iff (!rst_n)
    !(cd_s && sck_rise && ctl_cnt == 3'd7) |=> ($stable(sel_addr) && $stable(sel_rd)));

  a_r5_quiet_in_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    cd_s |-> !sio_oe);

  a_r4_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sio_out));

  a_r10_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(DEPTH)) |-> !rx_ready);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  a_r7_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !pop);
endmodule

bind sreg_port sreg_port_chk #(.DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cd_s(cd_s), .sck_rise(sck_rise),
  .sck_fall(sck_fall), .ctl_cnt(ctl_cnt), .sel_addr(sel_addr),
  .sel_rd(sel_rd), .sio_out(sio_out), .sio_oe(sio_oe),
  .rx_ready(rx_ready), .fifo_cnt(fifo_cnt), .pop(pop),
  .fifo_empty(fifo_empty));

// File: tb/sim_sreg_port.sv
module sim_sreg_port;
  localparam int DEPTH = 8;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b1, cd = 1'b0, sio_in = 1'b0;
  logic sio_out, sio_oe, rx_ready;
  logic wr_en = 1'b0, rx_valid = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0, rx_data = '0;

  int nvec = 0, nerr = 0;
  logic [7:0] model [16];
  logic [7:0] mq [$];

  always #10 clk = ~clk;

  sreg_port #(.RX_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cd(cd), .sio_in(sio_in),
    .sio_out(sio_out), .sio_oe(sio_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data));

  function automatic logic [7:0] ctl_word(input logic [3:0] a, input logic rd);
    return {3'b000, rd, a};
  endfunction

  function automatic logic [7:0] reg_expect(input logic [3:0] a);
    return (a == 4'hF) ? 8'h00 : model[a];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input logic [3:0] a, input logic rd, input int nbits);
    logic [7:0] w = ctl_word(a, rd);
    cd = 1'b1;
    wait_clk(HALF);
    check("R5 oe in control", {7'd0, sio_oe}, 8'd0);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; sio_in = w[i]; wait_clk(HALF);
      sck = 1'b1; wait_clk(HALF);
    end
    cd = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic rd_bits(input int n, output logic [7:0] b, output logic oe_ok);
    b = '0; oe_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; wait_clk(HALF);
      b[i] = sio_out;
      if (sio_oe !== 1'b1) oe_ok = 1'b0;
      sck = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic abort_read();
    cd = 1'b1; wait_clk(HALF);
    cd = 1'b0; wait_clk(HALF);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (a != 4'hF) model[a] = d;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 1'b0;
    mq.push_back(d);
  endtask

  task automatic try_push(input logic [7:0] d, output logic acc);
    @(negedge clk); acc = rx_ready; rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
    if (acc) mq.push_back(d);
  endtask

  task automatic rd_buf_expect(input string req);
    logic [7:0] b; logic ok;
    rd_bits(8, b, ok);
    check(req, b, (mq.size() > 0) ? mq.pop_front() : 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] b; logic ok, acc;
    void'($urandom(32'd7518));
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    wait_clk(4); rst_n = 1'b1; wait_clk(4);

    // R1: idle state after reset
    check("R1 oe after reset", {7'd0, sio_oe}, 8'd0);
    check("R1 rx_ready after reset", {7'd0, rx_ready}, 8'd1);
    rd_bits(8, b, ok);
    check("R1 write selected, no drive", {7'd0, ok}, 8'd0);

    // R11, R2, R4 directed
    wreg(4'h5, 8'hA6);
    ctl(4'h5, 1'b1, 8);
    rd_bits(8, b, ok);
    check("R4 read reg5", b, 8'hA6);
    check("R4 oe during read", {7'd0, ok}, 8'd1);
    rd_bits(8, b, ok);
    check("R6 repeat read", b, 8'hA6);

    // R3: partial control group discarded
    wreg(4'h9, 8'h3C);
    ctl(4'h9, 1'b1, 5);
    rd_bits(8, b, ok);
    check("R3 partial ignored", b, 8'hA6);

    // R9: mid-byte abort on plain register restarts at D0
    ctl(4'h9, 1'b1, 8);
    rd_bits(3, b, ok);
    abort_read();
    rd_bits(8, b, ok);
    check("R9 restart D0", b, 8'h3C);

    // R11, R7: write to buffer address ignored, empty reads 0
    wreg(4'hF, 8'h77);
    ctl(4'hF, 1'b1, 8);
    rd_buf_expect("R11/R7 empty buffer");

    // R2/R4/R11 random register traffic
    for (int k = 0; k < 20; k++) begin
      logic [3:0] a = 4'($urandom_range(0, 15));
      wreg(4'($urandom_range(0, 14)), 8'($urandom));
      ctl(a, 1'b1, 8);
      rd_bits(8, b, ok);
      if (a == 4'hF) check("R7 random empty", b, 8'h00);
      else check("R2 random read", b, reg_expect(a));
    end

    // R7: ordered buffer reads
    push(8'h11); push(8'h22); push(8'h33);
    ctl(4'hF, 1'b1, 8);
    for (int k = 0; k < 4; k++) rd_buf_expect("R7 buffer order");

    // R8: abort inside buffer byte skips it
    push(8'h4D); push(8'hB2);
    ctl(4'hF, 1'b1, 8);
    rd_bits(3, b, ok);
    void'(mq.pop_front());
    abort_read();
    rd_buf_expect("R8 next byte after abort");

    // R10: full queue stalls
    for (int k = 0; k < DEPTH; k++) push(8'($urandom));
    check("R10 ready low when full", {7'd0, rx_ready}, 8'd0);
    try_push(8'hEE, acc);
    check("R10 push refused", {7'd0, acc}, 8'd0);
    ctl(4'hF, 1'b1, 8);
    for (int k = 0; k < DEPTH + 1; k++) rd_buf_expect("R10 contents after full");

    // R7/R10: pushes racing pops
    for (int it = 0; it < 6; it++) begin
      push(8'($urandom)); push(8'($urandom));
      ctl(4'hF, 1'b1, 8);
      fork
        begin
          for (int k = 0; k < 4; k++) begin
            wait_clk($urandom_range(0, 20));
            push(8'($urandom));
          end
        end
        begin
          for (int k = 0; k < 6; k++) rd_buf_expect("R7 push/pop overlap");
        end
      join
      rd_buf_expect("R7 drained empty");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule